// File: doc/BRIEF.md
# PHY Configuration Test Port

This block turns a single 32-bit control word, written by software over a simple write-enable and data pair, into byte writes into the private configuration space of a multi-port PHY. Every port owns a small bank of 8-bit registers. Software composes a word holding write data, register address, port number, a write-enable flag, a test strobe and an active-low test reset. It then toggles the strobe bit in later writes of the same word. A write is committed only on the rising edge of that strobe.

The strobe bit passes through a synchroniser in the system clock domain and is then edge-detected. As a result, each rising edge yields one write no matter how long the bit stays high. A single bit of one register in port 0 drives the PHY clock enable. A read-back path returns any register of any port, so its contents can be checked.

Top module: `phy_tap_top`

## Requirements
- R1: After system reset the control word is zero, so the test reset is active. Every register of every port reads 0x00 and `phy_clk_en` is 0.
- R2: A rising edge of control bit 22 (strobe) commits a write, provided bit 21 (write enable) is 1 and bit 23 (test reset, active low) is 1. The write stores bits 7:0 (data) into the register at address bits 15:8 of the port given by bits 18:16.
- R3: One rising edge of the strobe commits exactly one write. While the strobe stays high, changing the data or address fields writes nothing, and the falling edge writes nothing.
- R4: A strobe rising edge with bit 21 clear leaves every register unchanged.
- R5: While bit 23 is 0, every register of every port is held at 0x00 and no strobe edge commits a write.
- R6: A write that selects a port number of NUM_PORTS or more, or a register address of REG_COUNT or more, is ignored.
- R7: `phy_clk_en` equals bit 2 of register 0x06 of port 0. Register 0x06 of any other port has no effect on it.
- R8: `rd_data` returns the register at `rd_addr` of port `rd_port`. It returns 0x00 when the port or the address is out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Loads `bus_wdata` into the control word |
| bus_wdata | input | 32 | New control word value |
| rd_port | input | 3 | Port selected for read-back |
| rd_addr | input | 8 | Register address for read-back |
| rd_data | output | 8 | Read-back byte |
| phy_clk_en | output | 1 | PHY clock enable, taken from port 0 register 0x06 bit 2 |

## Verification
The bench sweeps every port number from 0 to 2 and every address up to two past the last register, then reads back the full space against a bench model. A decoder that wraps port 2 onto port 0, or that aliases high addresses onto low ones, corrupts valid registers and fails that readback. The strobe is held high while the data field changes and is then dropped. A level-sensitive commit, or one that fires on the falling edge, overwrites the stored byte. Edges are also sent with the write enable clear and with the test reset asserted, which catches a design that skips either qualifier or clears the banks incompletely. Register 0x06 is written in port 1 and then in port 0, which exposes a clock enable tapped from the wrong port or bit.

// File: rtl/phy_tap_pkg.sv
package phy_tap_pkg;

  // Field layout of the software control word (bit positions are fixed).
  typedef struct packed {
    logic [7:0] rsvd_hi;   // 31:24
    logic       trst_n;    // 23 test reset, active low
    logic       strobe;    // 22 commit on rising edge
    logic       wen;       // 21 write enable
    logic [1:0] rsvd_mid;  // 20:19
    logic [2:0] port;      // 18:16
    logic [7:0] addr;      // 15:8
    logic [7:0] data;      // 7:0
  } ctl_word_t;

  localparam int CTL_W      = 32;
  localparam int PORT_W     = 3;
  localparam int BYTE_W     = 8;
  localparam int CLK_EN_REG = 6;
  localparam int CLK_EN_BIT = 2;

endpackage

// File: rtl/phy_tap_edge.sv
module phy_tap_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  // sh_q[SYNC_STAGES-1:0] is the synchroniser, sh_q[SYNC_STAGES] the previous value.
  logic [SYNC_STAGES:0] sh_q;
  logic [SYNC_STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[SYNC_STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

endmodule

// File: rtl/phy_tap_bank.sv
module phy_tap_bank #(
  parameter int REG_COUNT = 16,
  parameter int TAP_REG   = 6,
  parameter int TAP_BIT   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       tap
);

  localparam int         AW    = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;
  localparam logic [8:0] LIMIT = 9'(REG_COUNT);

  logic [REG_COUNT-1:0][7:0] regs_q;
  logic [REG_COUNT-1:0][7:0] regs_d;
  logic                      wr_hit;
  logic                      rd_hit;
  logic                      reg_ce;

  assign wr_hit = wr_en && ({1'b0, wr_addr} < LIMIT);
  assign rd_hit = ({1'b0, rd_addr} < LIMIT);
  assign reg_ce = clr | wr_hit;

  always_comb begin
    regs_d = regs_q;
    if (clr)         regs_d = '0;
    else if (wr_hit) regs_d[wr_addr[AW-1:0]] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      regs_q <= '0;
    else if (reg_ce) regs_q <= regs_d;
  end

  assign rd_data = rd_hit ? regs_q[rd_addr[AW-1:0]] : 8'h00;
  assign tap     = regs_q[TAP_REG][TAP_BIT];

endmodule

// File: rtl/phy_tap_top.sv
module phy_tap_top
  import phy_tap_pkg::*;
#(
  parameter int NUM_PORTS   = 2,
  parameter int REG_COUNT   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [CTL_W-1:0]  bus_wdata,
  input  logic [PORT_W-1:0] rd_port,
  input  logic [7:0]        rd_addr,
  output logic [7:0]        rd_data,
  output logic              phy_clk_en
);

  localparam logic [NUM_PORTS-1:0] TAP_MASK = NUM_PORTS'(1);

  // Reset: asynchronous assert, synchronous release.
  logic [1:0] rst_pipe_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ns = rst_pipe_q[1];

  // Control word register.
  ctl_word_t ctl_q;
  ctl_word_t ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (bus_we) ctl_d = ctl_word_t'(bus_wdata);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)     ctl_q <= '0;
    else if (bus_we) ctl_q <= ctl_d;
  end

  logic unused_rsvd;
  assign unused_rsvd = ^{ctl_q.rsvd_hi, ctl_q.rsvd_mid};

  logic test_rst_n;
  logic strobe_rise;
  logic commit;

  assign test_rst_n = ctl_q.trst_n;

  phy_tap_edge #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk  (clk),
    .rst_n(rst_ns),
    .din  (ctl_q.strobe),
    .rise (strobe_rise)
  );

  assign commit = strobe_rise & ctl_q.wen & test_rst_n;

  logic [NUM_PORTS-1:0][7:0] bank_rd;
  logic [NUM_PORTS-1:0]      bank_tap;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    phy_tap_bank #(
      .REG_COUNT(REG_COUNT),
      .TAP_REG  (CLK_EN_REG),
      .TAP_BIT  (CLK_EN_BIT)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_ns),
      .clr    (~test_rst_n),
      .wr_en  (commit && (ctl_q.port == PORT_W'(p))),
      .wr_addr(ctl_q.addr),
      .wr_data(ctl_q.data),
      .rd_addr(rd_addr),
      .rd_data(bank_rd[p]),
      .tap    (bank_tap[p])
    );
  end

  always_comb begin
    rd_data = 8'h00;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (rd_port == PORT_W'(p)) rd_data = bank_rd[p];
    end
  end

  assign phy_clk_en = |(bank_tap & TAP_MASK);

endmodule

// File: rtl/phy_tap_chk.sv
module phy_tap_chk #(
  parameter int NUM_PORTS = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       test_rst_n,
  input logic       strobe_rise,
  input logic       clk_en,
  input logic [2:0] rd_port,
  input logic [7:0] rd_data
);

  AST_SINGLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_rise |=> !strobe_rise);  // R3

  AST_TRESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !test_rst_n |=> !clk_en);  // R5

  AST_NO_EDGE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_rise && test_rst_n) |=> $stable(clk_en));  // R4

  AST_RD_PORT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ({29'b0, rd_port} >= NUM_PORTS) |-> (rd_data == 8'h00));  // R8

endmodule

bind phy_tap_top phy_tap_chk #(
  .NUM_PORTS(NUM_PORTS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_ns),
  .test_rst_n (test_rst_n),
  .strobe_rise(strobe_rise),
  .clk_en     (phy_clk_en),
  .rd_port    (rd_port),
  .rd_data    (rd_data)
);

// File: tb/phy_tap_top_tb.sv
module phy_tap_top_tb;

  localparam int NP = 2;
  localparam int NR = 16;

  logic        clk;
  logic        rst_n;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [2:0]  rd_port;
  logic [7:0]  rd_addr;
  logic [7:0]  rd_data;
  logic        phy_clk_en;

  int n_tests;
  int n_fail;
  logic [7:0] model [NP][NR];

  phy_tap_top #(.NUM_PORTS(NP), .REG_COUNT(NR), .SYNC_STAGES(2)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .rd_port   (rd_port),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .phy_clk_en(phy_clk_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] mk(input int p, input int a, input int d,
                                     input bit we, input bit stb, input bit trn);
    return {8'h00, trn, stb, we, 2'b00, 3'(p), 8'(a), 8'(d)};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [31:0] w);
    @(negedge clk);
    bus_we    = 1'b1;
    bus_wdata = w;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic strobe_write(input int p, input int a, input int d, input bit we);
    bus_write(mk(p, a, d, we, 1'b0, 1'b1));
    cyc(4);
    bus_write(mk(p, a, d, we, 1'b1, 1'b1));
    cyc(5);
    bus_write(mk(p, a, d, we, 1'b0, 1'b1));
    cyc(5);
  endtask

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic check_rd(input string tag, input int p, input int a, input logic [7:0] exp);
    @(negedge clk);
    rd_port = 3'(p);
    rd_addr = 8'(a);
    #1;
    check(tag, rd_data, exp);
  endtask

  task automatic check_all(input string tag);
    for (int p = 0; p < NP; p++)
      for (int a = 0; a < NR; a++)
        check_rd(tag, p, a, model[p][a]);
  endtask

  task automatic check_clk_en(input string tag, input logic exp);
    @(negedge clk);
    #1;
    check(tag, {7'b0, phy_clk_en}, {7'b0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests   = 0;
    n_fail    = 0;
    rst_n     = 1'b0;
    bus_we    = 1'b0;
    bus_wdata = '0;
    rd_port   = '0;
    rd_addr   = '0;
    for (int p = 0; p < NP; p++)
      for (int a = 0; a < NR; a++)
        model[p][a] = 8'h00;
    cyc(5);
    rst_n = 1'b1;
    cyc(4);

    // R1: reset state
    check_all("R1");
    check_clk_en("R1", 1'b0);

    // R2 / R6 / R8: sweep ports 0..2, addresses 0..NR+1
    for (int p = 0; p <= NP; p++)
      for (int a = 0; a < NR + 2; a++) begin
        int d;
        d = (p * 37 + a * 11 + 5) & 255;
        strobe_write(p, a, d, 1'b1);
        if (p < NP && a < NR) model[p][a] = 8'(d);
      end
    for (int p = 0; p <= NP; p++)
      for (int a = 0; a < NR + 2; a++) begin
        if (p < NP && a < NR) check_rd("R2", p, a, model[p][a]);
        else                  check_rd("R6,R8", p, a, 8'h00);
      end
    check_clk_en("R7", model[0][6][2]);

    // R3: hold the strobe high while changing data, then drop it
    bus_write(mk(1, 3, 8'h00, 1'b1, 1'b0, 1'b1));
    cyc(4);
    bus_write(mk(1, 3, 8'h22, 1'b1, 1'b1, 1'b1));
    cyc(5);
    model[1][3] = 8'h22;
    check_rd("R3", 1, 3, 8'h22);
    bus_write(mk(1, 3, 8'h33, 1'b1, 1'b1, 1'b1));
    cyc(5);
    check_rd("R3", 1, 3, 8'h22);
    bus_write(mk(1, 4, 8'h44, 1'b1, 1'b1, 1'b1));
    cyc(5);
    check_rd("R3", 1, 4, model[1][4]);
    bus_write(mk(1, 4, 8'h44, 1'b1, 1'b0, 1'b1));
    cyc(5);
    check_rd("R3", 1, 4, model[1][4]);
    check_rd("R3", 1, 3, 8'h22);

    // R4: strobe edge with write enable clear
    strobe_write(1, 3, 8'h55, 1'b0);
    check_rd("R4", 1, 3, 8'h22);
    strobe_write(0, 0, 8'h5A, 1'b0);
    check_rd("R4", 0, 0, model[0][0]);

    // R7: clock enable follows port 0 register 6 bit 2 only
    strobe_write(0, 6, 8'h00, 1'b1);
    model[0][6] = 8'h00;
    check_clk_en("R7", 1'b0);
    strobe_write(1, 6, 8'h04, 1'b1);
    model[1][6] = 8'h04;
    check_clk_en("R7", 1'b0);
    strobe_write(0, 6, 8'h04, 1'b1);
    model[0][6] = 8'h04;
    check_clk_en("R7", 1'b1);
    strobe_write(0, 6, 8'hFB, 1'b1);
    model[0][6] = 8'hFB;
    check_clk_en("R7", 1'b0);
    strobe_write(0, 6, 8'h04, 1'b1);
    model[0][6] = 8'h04;
    check_clk_en("R7", 1'b1);

    // R5: test reset clears every bank and blocks writes
    bus_write(mk(0, 6, 8'h04, 1'b1, 1'b0, 1'b0));
    cyc(3);
    for (int p = 0; p < NP; p++)
      for (int a = 0; a < NR; a++)
        model[p][a] = 8'h00;
    check_clk_en("R5", 1'b0);
    check_all("R5");
    bus_write(mk(0, 6, 8'h99, 1'b1, 1'b1, 1'b0));
    cyc(5);
    bus_write(mk(0, 6, 8'h99, 1'b1, 1'b0, 1'b0));
    cyc(5);
    bus_write(mk(0, 6, 8'h99, 1'b1, 1'b0, 1'b1));
    cyc(5);
    check_rd("R5", 0, 6, 8'h00);
    check_clk_en("R5", 1'b0);

    // R2 after test reset release: normal writes resume
    strobe_write(1, 15, 8'hC3, 1'b1);
    check_rd("R2", 1, 15, 8'hC3);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule